// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides whether a transaction seen on the primary side of a PCI-to-PCI bridge should be passed to the secondary side. It takes the request address and its space type (I/O or memory). It also takes the bridge's base and limit configuration fields exactly as they are packed in configuration space. From these it rebuilds three forwarding windows: an I/O window, a non-prefetchable memory window and a prefetchable memory window. When the legacy display enable is set, it adds the fixed legacy display ranges.

Each window has its own granularity. The I/O window uses 4 KB units, with an optional 32-bit extension. The non-prefetchable memory window uses 1 MB units within the low 4 GB. The prefetchable window uses 1 MB units, with an optional 64-bit extension. The command-register space enables gate the regular windows. The decision is registered: one cycle after a request strobe, the block presents a response strobe, a per-window hit vector and a forward flag.

Top module: `bridge_window_decode`

## Requirements
- R1: I/O window in 16-bit mode (bit 0 of the register's low nibble clear): the base is `io_base_lo[7:4]` placed at address bits 15:12 with zeros below. The limit is `io_limit_lo[7:4]` at bits 15:12 with bits 11:0 all ones. Bits 31:16 are zero. An I/O request hits (`rsp_hit[0]`) when base <= address[31:0] <= limit.
- R2: 32-bit I/O mode is chosen separately for base and limit, by bit 0 of `io_base_lo` and of `io_limit_lo`. When that bit is set, bits 31:16 of the bound come from `io_base_hi` or `io_limit_hi`. Otherwise those upper registers are ignored.
- R3: The non-prefetchable memory window (`rsp_hit[1]`) has its base at `mem_base[15:4]` << 20 and its limit at (`mem_limit[15:4]` << 20) | 0xFFFFF. The bound is compared over all 64 address bits, with bits 63:32 zero. The low nibbles of both registers are ignored.
- R4: The prefetchable window (`rsp_hit[2]`) is built like R3 from `pf_base` and `pf_limit`. When bit 0 of `pf_base` is set, `pf_base_hi` supplies bits 63:32 of the base. When bit 0 of `pf_limit` is set, `pf_limit_hi` supplies bits 63:32 of the limit. Otherwise those bits are zero.
- R5: `cmd_io_en` low suppresses `rsp_hit[0]`. `cmd_mem_en` low suppresses `rsp_hit[1]` and `rsp_hit[2]`. The enables do not affect the legacy ranges.
- R6: A window whose limit is below its base never hits.
- R7: With `vga_en` set, I/O requests in 0x3B0..0x3BB or 0x3C0..0x3DF set `rsp_hit[3]`. Memory requests in 0xA0000..0xBFFFF (64-bit compare) set `rsp_hit[4]`. With `vga_en` clear, both bits stay zero.
- R8: I/O requests (`req_is_io`=1) never set `rsp_hit[1]`, `rsp_hit[2]` or `rsp_hit[4]`, and they use only address bits 31:0. Memory requests never set `rsp_hit[0]` or `rsp_hit[3]`.
- R9: `rsp_valid` rises exactly one cycle after `req_valid`. When `rsp_valid` is low, `rsp_hit` and `rsp_fwd` are zero. All three outputs are zero during reset.
- R10: `rsp_fwd` is the OR of the five bits of `rsp_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 64 | Request address |
| cmd_io_en | input | 1 | I/O space enable |
| cmd_mem_en | input | 1 | Memory space enable |
| vga_en | input | 1 | Legacy display range enable |
| io_base_lo | input | 8 | Packed I/O base field |
| io_limit_lo | input | 8 | Packed I/O limit field |
| io_base_hi | input | 16 | I/O base bits 31:16 |
| io_limit_hi | input | 16 | I/O limit bits 31:16 |
| mem_base | input | 16 | Packed memory base field |
| mem_limit | input | 16 | Packed memory limit field |
| pf_base | input | 16 | Packed prefetchable base field |
| pf_limit | input | 16 | Packed prefetchable limit field |
| pf_base_hi | input | 32 | Prefetchable base bits 63:32 |
| pf_limit_hi | input | 32 | Prefetchable limit bits 63:32 |
| rsp_valid | output | 1 | Response strobe |
| rsp_fwd | output | 1 | Forward downstream |
| rsp_hit | output | 5 | Hits: 0 I/O, 1 mem, 2 prefetch, 3 legacy I/O, 4 legacy mem |

## Verification
The bench sweeps every base/limit nibble pair of the I/O and memory windows. It probes one below the base, the base, the limit and one above the limit. An off-by-one or wrong-granularity fill therefore shows up as a missed or extra hit at an edge. Inverted pairs catch a decoder that lets empty windows match. Sweeps over the extended upper registers, with the mode bit set on only one side, catch a design that shares one type bit between base and limit, or that forgets to zero the upper bits. The bench steps through every address around the legacy display ranges, so a design with a wrong range end forwards the gap at 0x3BC..0x3BF or misses 0x3DF. I/O requests carrying junk in the upper address bits, and memory requests at legacy I/O addresses, catch confusion between the two spaces.

// File: rtl/bridge_window_decode.sv
module bridge_window_decode #(
  parameter int IO_GRAN  = 12,
  parameter int MEM_GRAN = 20,
  parameter logic [31:0] LIO_LO_BASE = 32'h3B0,
  parameter logic [31:0] LIO_LO_LAST = 32'h3BB,
  parameter logic [31:0] LIO_HI_BASE = 32'h3C0,
  parameter logic [31:0] LIO_HI_LAST = 32'h3DF,
  parameter logic [63:0] LMEM_BASE   = 64'hA0000,
  parameter logic [63:0] LMEM_LAST   = 64'hBFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_is_io,
  input  logic [63:0] req_addr,
  input  logic        cmd_io_en,
  input  logic        cmd_mem_en,
  input  logic        vga_en,
  input  logic [7:0]  io_base_lo,
  input  logic [7:0]  io_limit_lo,
  input  logic [15:0] io_base_hi,
  input  logic [15:0] io_limit_hi,
  input  logic [15:0] mem_base,
  input  logic [15:0] mem_limit,
  input  logic [15:0] pf_base,
  input  logic [15:0] pf_limit,
  input  logic [31:0] pf_base_hi,
  input  logic [31:0] pf_limit_hi,
  output logic        rsp_valid,
  output logic        rsp_fwd,
  output logic [4:0]  rsp_hit
);
  localparam int NWIN = 5;
  localparam logic [31:0] IO_FILL  = (32'd1 << IO_GRAN) - 32'd1;
  localparam logic [63:0] MEM_FILL = (64'd1 << MEM_GRAN) - 64'd1;

  logic [31:0] a32;
  logic [31:0] io_b, io_l;
  logic [63:0] mem_b, mem_l, pf_b, pf_l;
  logic        is_mem;
  logic [NWIN-1:0] hit;

  assign a32    = req_addr[31:0];
  assign is_mem = !req_is_io;

  assign io_b = {io_base_lo[0]  ? io_base_hi  : 16'h0, io_base_lo[7:4],  12'h000};
  assign io_l = {io_limit_lo[0] ? io_limit_hi : 16'h0, io_limit_lo[7:4], 12'h000} | IO_FILL;

  assign mem_b = {32'h0, mem_base[15:4],  20'h0};
  assign mem_l = {32'h0, mem_limit[15:4], 20'h0} | MEM_FILL;

  assign pf_b = {pf_base[0]  ? pf_base_hi  : 32'h0, pf_base[15:4],  20'h0};
  assign pf_l = {pf_limit[0] ? pf_limit_hi : 32'h0, pf_limit[15:4], 20'h0} | MEM_FILL;

  assign hit[0] = req_is_io && cmd_io_en && (io_l >= io_b) &&
                  (a32 >= io_b) && (a32 <= io_l);
  assign hit[1] = is_mem && cmd_mem_en && (mem_l >= mem_b) &&
                  (req_addr >= mem_b) && (req_addr <= mem_l);
  assign hit[2] = is_mem && cmd_mem_en && (pf_l >= pf_b) &&
                  (req_addr >= pf_b) && (req_addr <= pf_l);
  assign hit[3] = req_is_io && vga_en &&
                  (((a32 >= LIO_LO_BASE) && (a32 <= LIO_LO_LAST)) ||
                   ((a32 >= LIO_HI_BASE) && (a32 <= LIO_HI_LAST)));
  assign hit[4] = is_mem && vga_en &&
                  (req_addr >= LMEM_BASE) && (req_addr <= LMEM_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= '0;
      rsp_fwd   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid ? hit : '0;
      rsp_fwd   <= req_valid && (|hit);
    end
  end
endmodule

module bridge_window_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_is_io,
  input logic        cmd_io_en,
  input logic        cmd_mem_en,
  input logic        vga_en,
  input logic [15:0] mem_base,
  input logic [15:0] mem_limit,
  input logic        rsp_valid,
  input logic        rsp_fwd,
  input logic [4:0]  rsp_hit
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_hit == 5'b0 && !rsp_fwd));
  // R5
  io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cmd_io_en) |=> !rsp_hit[0]);
  // R5
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cmd_mem_en) |=> rsp_hit[2:1] == 2'b00);
  // R7
  legacy_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !vga_en) |=> rsp_hit[4:3] == 2'b00);
  // R8
  io_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_io) |=> (rsp_hit[2:1] == 2'b00 && !rsp_hit[4]));
  // R8
  mem_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io) |=> (!rsp_hit[0] && !rsp_hit[3]));
  // R6
  empty_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mem_limit[15:4] < mem_base[15:4]) |=> !rsp_hit[1]);
endmodule

bind bridge_window_decode bridge_window_decode_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
  .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en), .vga_en(vga_en),
  .mem_base(mem_base), .mem_limit(mem_limit),
  .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd), .rsp_hit(rsp_hit)
);

// File: tb/bridge_window_decode_tb_top.sv
module bridge_window_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, req_valid, req_is_io, cmd_io_en, cmd_mem_en, vga_en;
  logic [63:0] req_addr;
  logic [7:0]  io_base_lo, io_limit_lo;
  logic [15:0] io_base_hi, io_limit_hi, mem_base, mem_limit, pf_base, pf_limit;
  logic [31:0] pf_base_hi, pf_limit_hi;
  logic        rsp_valid, rsp_fwd;
  logic [4:0]  rsp_hit;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bridge_window_decode dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_addr(req_addr), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
    .vga_en(vga_en), .io_base_lo(io_base_lo), .io_limit_lo(io_limit_lo),
    .io_base_hi(io_base_hi), .io_limit_hi(io_limit_hi), .mem_base(mem_base),
    .mem_limit(mem_limit), .pf_base(pf_base), .pf_limit(pf_limit),
    .pf_base_hi(pf_base_hi), .pf_limit_hi(pf_limit_hi),
    .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd), .rsp_hit(rsp_hit)
  );

  function automatic logic [63:0] io_lo_bound();
    return 64'(io_base_lo / 16) * 4096 + (io_base_lo % 2 ? 64'(io_base_hi) * 65536 : 0);
  endfunction
  function automatic logic [63:0] io_hi_bound();
    return 64'(io_limit_lo / 16) * 4096 + 4095 + (io_limit_lo % 2 ? 64'(io_limit_hi) * 65536 : 0);
  endfunction
  function automatic logic [63:0] mem_lo_bound();
    return 64'(mem_base / 16) * 64'h100000;
  endfunction
  function automatic logic [63:0] mem_hi_bound();
    return 64'(mem_limit / 16) * 64'h100000 + 64'hFFFFF;
  endfunction
  function automatic logic [63:0] pf_lo_bound();
    return 64'(pf_base / 16) * 64'h100000 + (pf_base % 2 ? 64'(pf_base_hi) * 64'h100000000 : 0);
  endfunction
  function automatic logic [63:0] pf_hi_bound();
    return 64'(pf_limit / 16) * 64'h100000 + 64'hFFFFF +
           (pf_limit % 2 ? 64'(pf_limit_hi) * 64'h100000000 : 0);
  endfunction

  function automatic logic [4:0] expect_hits();
    logic [4:0]  e = '0;
    logic [63:0] a = req_is_io ? (req_addr % 64'h100000000) : req_addr;
    if (req_is_io) begin
      e[0] = cmd_io_en && a >= io_lo_bound() && a <= io_hi_bound();
      e[3] = vga_en && ((a >= 944 && a <= 955) || (a >= 960 && a <= 991));
    end else begin
      e[1] = cmd_mem_en && a >= mem_lo_bound() && a <= mem_hi_bound();
      e[2] = cmd_mem_en && a >= pf_lo_bound() && a <= pf_hi_bound();
      e[4] = vga_en && a >= 655360 && a <= 786431;
    end
    return e;
  endfunction

  task automatic probe(input string tag);
    logic [4:0] e;
    e = expect_hits();
    req_valid = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== e || rsp_fwd !== (|e)) begin
      errors++;
      $display("FAIL %s addr=%h io=%0b: valid=%b hit=%b fwd=%b expected valid=1 hit=%b fwd=%b",
               tag, req_addr, req_is_io, rsp_valid, rsp_hit, rsp_fwd, e, |e);
    end
  endtask

  task automatic probe_edges(input string tag, input logic [63:0] lo, input logic [63:0] hi);
    req_addr = lo - 1; probe(tag);
    req_addr = lo;     probe(tag);
    req_addr = hi;     probe(tag);
    req_addr = hi + 1; probe(tag);
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 5'b0 || rsp_fwd !== 1'b0) begin
      errors++;
      $display("FAIL %s: valid=%b hit=%b fwd=%b expected 0 0 0", tag, rsp_valid, rsp_hit, rsp_fwd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b1; req_is_io = 1'b0; req_addr = 64'hA0000;
    cmd_io_en = 1'b1; cmd_mem_en = 1'b1; vga_en = 1'b1;
    io_base_lo = 0; io_limit_lo = 8'hF0; io_base_hi = 0; io_limit_hi = 0;
    mem_base = 0; mem_limit = 16'hFFF0; pf_base = 0; pf_limit = 16'hFFF0;
    pf_base_hi = 0; pf_limit_hi = 0;
    repeat (3) @(negedge clk);
    check_idle("R9 reset");
    rst_n = 1'b1;

    // R1 R6: 16-bit I/O window, all nibble pairs
    cmd_mem_en = 1'b0; vga_en = 1'b0; req_is_io = 1'b1;
    for (int b = 0; b < 16; b++)
      for (int l = 0; l < 16; l++) begin
        io_base_lo = 8'(b * 16); io_limit_lo = 8'(l * 16);
        io_base_hi = 16'h55AA; io_limit_hi = 16'hAA55;
        probe_edges(l < b ? "R6 io" : "R1 io", io_lo_bound(), io_hi_bound());
      end

    // R2 R8: 32-bit I/O, mode bit per side, junk upper address
    for (int m = 0; m < 4; m++)
      for (int hb = 0; hb < 3; hb++)
        for (int hl = 0; hl < 3; hl++) begin
          io_base_lo = 8'h20 | 8'(m % 2); io_limit_lo = 8'h40 | 8'(m / 2);
          io_base_hi = 16'(hb); io_limit_hi = 16'(hl);
          probe_edges("R2 io32", io_lo_bound(), io_hi_bound());
          req_addr = io_lo_bound() | 64'hDEAD_0000_0000_0000; probe("R8 io upper");
        end

    // R3 R6: memory window, all index pairs, junk low nibbles
    req_is_io = 1'b0; cmd_io_en = 1'b0; cmd_mem_en = 1'b1;
    pf_base = 16'hFFF0; pf_limit = 16'h0000;
    for (int b = 0; b < 16; b++)
      for (int l = 0; l < 16; l++) begin
        mem_base = 16'(b * 4096) | 16'h000A; mem_limit = 16'(l * 4096) | 16'h0005;
        probe_edges(l < b ? "R6 mem" : "R3 mem", mem_lo_bound(), mem_hi_bound());
      end

    // R4: prefetchable, 64-bit mode per side
    mem_base = 16'hFFF0; mem_limit = 16'h0000;
    for (int m = 0; m < 4; m++)
      for (int hb = 0; hb < 3; hb++)
        for (int hl = 0; hl < 3; hl++)
          for (int lo = 0; lo < 3; lo++) begin
            pf_base = 16'(lo * 16'h2000) | 16'(m % 2);
            pf_limit = 16'h4000 | 16'(m / 2);
            pf_base_hi = 32'(hb); pf_limit_hi = 32'(hl);
            probe_edges("R4 pf", pf_lo_bound(), pf_hi_bound());
          end

    // R5: enables against fixed windows
    io_base_lo = 8'h10; io_limit_lo = 8'h20; mem_base = 16'h1000; mem_limit = 16'h1000;
    pf_base = 16'h2000; pf_limit = 16'h2000; vga_en = 1'b0;
    for (int en = 0; en < 4; en++) begin
      cmd_io_en = en[0]; cmd_mem_en = en[1];
      req_is_io = 1'b1; req_addr = 64'h1800;     probe("R5 io en");
      req_is_io = 1'b0; req_addr = 64'h10080000; probe("R5 mem en");
      req_is_io = 1'b0; req_addr = 64'h20000000; probe("R5 pf en");
    end

    // R7 R8: legacy display ranges, independent of space enables
    cmd_io_en = 1'b0; cmd_mem_en = 1'b0;
    for (int v = 0; v < 2; v++) begin
      vga_en = v[0];
      req_is_io = 1'b1;
      for (int a = 32'h3A8; a < 32'h3E8; a++) begin
        req_addr = 64'(a); probe("R7 legacy io");
      end
      req_is_io = 1'b0;
      probe_edges("R7 legacy mem", 64'hA0000, 64'hBFFFF);
      req_addr = 64'h3C0; probe("R8 mem at io");
      req_addr = 64'h1_000A_0000; probe("R7 mem upper");
      req_is_io = 1'b1; req_addr = 64'hA0000; probe("R8 io at mem");
    end

    // R9 R10: idle after traffic
    req_valid = 1'b0;
    @(negedge clk);
    check_idle("R9 idle");
    @(negedge clk);
    check_idle("R10 idle");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule